// File: doc/BRIEF.md
# Selectable Line Error Counter

This block tallies one chosen class of receive-line errors in a 16-bit counter and moves the tally into a pair of read-only byte registers. Per-bit error pulses for pattern logic errors, excess-zero errors and bipolar code violations arrive from the receive path. A 2-bit selector decides which pulses are counted. One selector setting counts code violations and excess zeros together.

A report is a transfer. It copies the running count into both result bytes in the same cycle and restarts the counter. In manual report mode, software causes a transfer by taking the transfer bit from 0 to 1. In automatic report mode, every one-second tick causes a transfer.

The block raises a one-cycle event when the counter saturates. It also raises a one-cycle timer event for every one-second tick.

Top module: `line_err_tally`

## Requirements
- R1: With select code 00, each cycle with `pat_err_i` high adds 1 to the count, and the other error inputs are not counted.
- R2: With select code 01, each cycle with `exz_err_i` high adds 1 to the count, and the other error inputs are not counted.
- R3: With select code 10, each cycle with `cv_err_i` high adds 1 to the count, and the other error inputs are not counted.
- R4: With select code 11, `cv_err_i` and `exz_err_i` are both counted. A cycle with both high adds 2, and `pat_err_i` is not counted.
- R5: With `auto_mode_i` = 0, a 0-to-1 change of `xfer_bit_i` (sampled at consecutive clock edges) performs a transfer. Holding the bit at 1 performs no further transfer. The bit must return to 0 before the next transfer can occur.
- R6: With `auto_mode_i` = 1, each cycle with `sec_tick_i` high performs a transfer, and `xfer_bit_i` has no effect on the count or the results. With `auto_mode_i` = 0, `sec_tick_i` causes no transfer.
- R7: The count saturates at 0xFFFF and does not wrap. The edge at which an increment would pass 0xFFFF raises `ovf_evt_o` for exactly one cycle. Further errors while saturated raise no further pulse.
- R8: A transfer copies the count into `{res_hi_o, res_lo_o}` (high byte = bits 15:8) and restarts the count at the increment selected in that same cycle, so that an error coincident with the transfer lands in the new interval.
- R9: Both result bytes change only at a transfer, and they always change together.
- R10: `tick_evt_o` is high in the cycle after each cycle in which `sec_tick_i` is high, in either mode.
- R11: After the synchronous active-high reset, the count, both result bytes and both event outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| pat_err_i | input | 1 | Pattern logic error pulse, one per bit period |
| exz_err_i | input | 1 | Excess-zero error pulse |
| cv_err_i | input | 1 | Bipolar code violation pulse |
| sec_tick_i | input | 1 | One-second timer tick, one cycle wide |
| sel_i | input | 2 | Error class select: 00 pattern, 01 excess zeros, 10 code violations, 11 both line errors |
| auto_mode_i | input | 1 | 0 = manual report, 1 = automatic report on each tick |
| xfer_bit_i | input | 1 | Manual transfer request; acts on its rising change |
| res_lo_o | output | 8 | Result byte, count bits 7:0 |
| res_hi_o | output | 8 | Result byte, count bits 15:8 |
| ovf_evt_o | output | 1 | One-cycle counter saturation event |
| tick_evt_o | output | 1 | One-cycle timer expiry event |

## Verification
The assertions assume that `sec_tick_i` is a single-cycle strobe. They also assume that every input is synchronous to `clk` and steady across each edge.

The stimulus drives every input half a cycle away from the sampling edge. It keeps `sec_tick_i` sparse. It mixes random error densities with runs in which the transfer bit is held high, steps in which the mode changes, and a long run of paired errors that drives the counter into saturation. Expected counts, result bytes and events come from a cycle-level model in the bench, and every output is compared after every edge.

// File: rtl/let_pkg.sv
package let_pkg;
  typedef enum logic [1:0] {
    SEL_PAT  = 2'b00,
    SEL_EXZ  = 2'b01,
    SEL_CV   = 2'b10,
    SEL_LINE = 2'b11
  } err_sel_e;

  localparam int unsigned INC_W = 2;
endpackage

// File: rtl/let_err_pick.sv
module let_err_pick
  import let_pkg::*;
(
  input  logic             pat_err_i,
  input  logic             exz_err_i,
  input  logic             cv_err_i,
  input  logic [1:0]       sel_i,
  output logic [INC_W-1:0] inc_o
);
  err_sel_e sel;
  assign sel = err_sel_e'(sel_i);

  always_comb begin
    unique case (sel)
      SEL_PAT:  inc_o = {1'b0, pat_err_i};
      SEL_EXZ:  inc_o = {1'b0, exz_err_i};
      SEL_CV:   inc_o = {1'b0, cv_err_i};
      SEL_LINE: inc_o = {1'b0, cv_err_i} + {1'b0, exz_err_i};
      default:  inc_o = '0;
    endcase
  end
endmodule

// File: rtl/let_xfer_ctl.sv
module let_xfer_ctl (
  input  logic clk,
  input  logic rst,
  input  logic auto_mode_i,
  input  logic xfer_bit_i,
  input  logic sec_tick_i,
  output logic fire_o,
  output logic tick_evt_o
);
  logic bit_q;
  logic man_rise;

  assign man_rise = xfer_bit_i & ~bit_q;
  assign fire_o   = auto_mode_i ? sec_tick_i : man_rise;

  always_ff @(posedge clk) begin
    if (rst) begin
      bit_q      <= 1'b0;
      tick_evt_o <= 1'b0;
    end else begin
      bit_q      <= xfer_bit_i;
      tick_evt_o <= sec_tick_i;
    end
  end
endmodule

// File: rtl/let_sat_cnt.sv
module let_sat_cnt #(
  parameter int unsigned CNT_W = 16,
  parameter int unsigned INC_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             restart_i,
  input  logic [INC_W-1:0] inc_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             ovf_o
);
  localparam logic [CNT_W-1:0] MAXV = {CNT_W{1'b1}};

  logic [CNT_W:0]   sum;
  logic [CNT_W-1:0] inc_ext;

  assign inc_ext = CNT_W'(inc_i);
  assign sum     = {1'b0, cnt_o} + {1'b0, inc_ext};

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_o <= '0;
      ovf_o <= 1'b0;
    end else if (restart_i) begin
      cnt_o <= inc_ext;
      ovf_o <= 1'b0;
    end else if (sum[CNT_W]) begin
      cnt_o <= MAXV;
      ovf_o <= (cnt_o != MAXV);
    end else begin
      cnt_o <= sum[CNT_W-1:0];
      ovf_o <= 1'b0;
    end
  end
endmodule

// File: rtl/let_report.sv
module let_report #(
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned BYTE_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load_i,
  input  logic [CNT_W-1:0] cnt_i,
  output logic [CNT_W-1:0] res_o
);
  localparam int unsigned N_LANES = CNT_W / BYTE_W;

  for (genvar g = 0; g < N_LANES; g++) begin : g_lane
    always_ff @(posedge clk) begin
      if (rst)
        res_o[g*BYTE_W +: BYTE_W] <= '0;
      else if (load_i)
        res_o[g*BYTE_W +: BYTE_W] <= cnt_i[g*BYTE_W +: BYTE_W];
    end
  end
endmodule

// File: rtl/line_err_tally.sv
module line_err_tally
  import let_pkg::*;
#(
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pat_err_i,
  input  logic              exz_err_i,
  input  logic              cv_err_i,
  input  logic              sec_tick_i,
  input  logic [1:0]        sel_i,
  input  logic              auto_mode_i,
  input  logic              xfer_bit_i,
  output logic [BYTE_W-1:0] res_lo_o,
  output logic [BYTE_W-1:0] res_hi_o,
  output logic              ovf_evt_o,
  output logic              tick_evt_o
);
  logic [INC_W-1:0] inc;
  logic             fire;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] res_q;

  let_err_pick u_pick (
    .pat_err_i (pat_err_i),
    .exz_err_i (exz_err_i),
    .cv_err_i  (cv_err_i),
    .sel_i     (sel_i),
    .inc_o     (inc)
  );

  let_xfer_ctl u_xfer (
    .clk         (clk),
    .rst         (rst),
    .auto_mode_i (auto_mode_i),
    .xfer_bit_i  (xfer_bit_i),
    .sec_tick_i  (sec_tick_i),
    .fire_o      (fire),
    .tick_evt_o  (tick_evt_o)
  );

  let_sat_cnt #(.CNT_W(CNT_W), .INC_W(INC_W)) u_cnt (
    .clk       (clk),
    .rst       (rst),
    .restart_i (fire),
    .inc_i     (inc),
    .cnt_o     (cnt_q),
    .ovf_o     (ovf_evt_o)
  );

  let_report #(.CNT_W(CNT_W), .BYTE_W(BYTE_W)) u_rep (
    .clk    (clk),
    .rst    (rst),
    .load_i (fire),
    .cnt_i  (cnt_q),
    .res_o  (res_q)
  );

  assign res_lo_o = res_q[BYTE_W-1:0];
  assign res_hi_o = res_q[2*BYTE_W-1:BYTE_W];
endmodule

// File: rtl/line_err_tally_chk.sv
module line_err_tally_chk #(
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned BYTE_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              sec_tick_i,
  input logic              auto_mode_i,
  input logic              fire,
  input logic [CNT_W-1:0]  cnt_q,
  input logic [BYTE_W-1:0] res_lo_o,
  input logic [BYTE_W-1:0] res_hi_o,
  input logic              ovf_evt_o,
  input logic              tick_evt_o
);
  localparam logic [CNT_W-1:0] MAXV = {CNT_W{1'b1}};

  // R7: the saturation event never lasts two cycles
  a_r7_single_pulse: assert property (@(posedge clk) disable iff (rst)
    ovf_evt_o |=> !ovf_evt_o);

  // R7: a saturated count stays saturated until a transfer
  a_r7_no_wrap: assert property (@(posedge clk) disable iff (rst)
    (cnt_q == MAXV && !fire) |=> (cnt_q == MAXV));

  // R9: both result bytes hold their value when there is no transfer
  a_r9_hold: assert property (@(posedge clk) disable iff (rst)
    !fire |=> $stable({res_hi_o, res_lo_o}));

  // R6: in automatic mode the results change only after a tick
  a_r6_auto_only_tick: assert property (@(posedge clk) disable iff (rst)
    (auto_mode_i && !sec_tick_i) |=> $stable({res_hi_o, res_lo_o}));

  // R10: each tick produces a timer event one cycle later
  a_r10_tick_evt: assert property (@(posedge clk) disable iff (rst)
    sec_tick_i |=> tick_evt_o);

  // R5: a manual transfer is not repeated on the next cycle
  a_r5_one_shot: assert property (@(posedge clk) disable iff (rst)
    (fire && !auto_mode_i) |=> (auto_mode_i || !fire));

  // R8: the count restarts small after a transfer
  a_r8_restart: assert property (@(posedge clk) disable iff (rst)
    fire |=> (cnt_q <= CNT_W'(2)));
endmodule

bind line_err_tally line_err_tally_chk #(.CNT_W(CNT_W), .BYTE_W(BYTE_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .sec_tick_i  (sec_tick_i),
  .auto_mode_i (auto_mode_i),
  .fire        (fire),
  .cnt_q       (cnt_q),
  .res_lo_o    (res_lo_o),
  .res_hi_o    (res_hi_o),
  .ovf_evt_o   (ovf_evt_o),
  .tick_evt_o  (tick_evt_o)
);

// File: tb/line_err_tally_bench.sv
module line_err_tally_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       pat = 1'b0, exz = 1'b0, cv = 1'b0, tick = 1'b0;
  logic [1:0] sel = 2'b00;
  logic       amode = 1'b0, xbit = 1'b0;
  logic [7:0] lo, hi;
  logic       ovf, tevt;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  // bench model
  int unsigned m_cnt = 0, m_res = 0;
  bit m_xq = 0, m_ovf = 0, m_tick = 0;

  always #4 clk = ~clk;

  line_err_tally u_line_err_tally (
    .clk(clk), .rst(rst), .pat_err_i(pat), .exz_err_i(exz), .cv_err_i(cv),
    .sec_tick_i(tick), .sel_i(sel), .auto_mode_i(amode), .xfer_bit_i(xbit),
    .res_lo_o(lo), .res_hi_o(hi), .ovf_evt_o(ovf), .tick_evt_o(tevt)
  );

  function automatic int unsigned incr(logic [1:0] s, logic p, logic e, logic c);
    case (s)
      2'b00:   return int'(p);
      2'b01:   return int'(e);
      2'b10:   return int'(c);
      default: return int'(c) + int'(e);
    endcase
  endfunction

  function automatic bit xfer_now(bit a, bit b, bit q, bit t);
    return a ? t : (b && !q);
  endfunction

  task automatic chk(string req, int unsigned act, int unsigned exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // drive at the negative edge, step the model at the positive edge,
  // compare at the following negative edge
  task automatic step(string req, logic p, logic e, logic c, logic t,
                      logic [1:0] s, logic a, logic b);
    int unsigned inc, sum;
    bit fire;
    pat = p; exz = e; cv = c; tick = t; sel = s; amode = a; xbit = b;
    @(posedge clk);
    inc  = incr(s, p, e, c);
    fire = xfer_now(a, b, m_xq, t);
    if (fire) begin
      m_res = m_cnt; m_cnt = inc; m_ovf = 0;
    end else begin
      sum = m_cnt + inc;
      if (sum > 32'hFFFF) begin
        m_ovf = (m_cnt != 32'hFFFF); m_cnt = 32'hFFFF;
      end else begin
        m_ovf = 0; m_cnt = sum;
      end
    end
    m_xq = b; m_tick = t;
    @(negedge clk);
    chk({req, " R9 result"}, {24'd0, hi, lo}, m_res);
    chk({req, " R7 ovf"}, ovf, m_ovf);
    chk({req, " R10 tick"}, tevt, m_tick);
  endtask

  // transfer to read back the running count
  task automatic readout(string req, logic a);
    if (a) step(req, 0, 0, 0, 1, 2'b00, 1'b1, 1'b0);
    else begin
      step(req, 0, 0, 0, 0, 2'b00, 1'b0, 1'b1);
      step(req, 0, 0, 0, 0, 2'b00, 1'b0, 1'b0);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R11: reset state
    chk("R11 lo", lo, 0); chk("R11 hi", hi, 0);
    chk("R11 ovf", ovf, 0); chk("R11 tick", tevt, 0);

    // R1..R4: each select with all three error inputs toggling
    for (int s = 0; s < 4; s++) begin
      for (int i = 0; i < 9; i++)
        step("R1R4", logic'(i % 2), logic'(i % 3 == 0), logic'(i % 4 < 2),
             1'b0, 2'(s), 1'b0, 1'b0);
      readout("R1R4", 1'b0);
      case (s)
        0: chk("R1 pattern count", {hi, lo}, 4);
        1: chk("R2 exz count", {hi, lo}, 3);
        2: chk("R3 cv count", {hi, lo}, 5);
        default: chk("R4 combined count", {hi, lo}, 8);
      endcase
    end

    // R4: coincident pair adds 2
    step("R4", 1, 1, 1, 0, 2'b11, 0, 0);
    readout("R4", 1'b0);
    chk("R4 pair adds two", {hi, lo}, 2);

    // R5: held bit transfers once
    step("R5", 0, 0, 1, 0, 2'b10, 0, 0);
    step("R5", 0, 0, 0, 0, 2'b10, 0, 1);
    chk("R5 first transfer", {hi, lo}, 1);
    for (int i = 0; i < 4; i++) step("R5", 0, 0, 1, 0, 2'b10, 0, 1);
    chk("R5 held bit no transfer", {hi, lo}, 1);
    step("R5", 0, 0, 0, 0, 2'b10, 0, 0);
    step("R5", 0, 0, 0, 0, 2'b10, 0, 1);
    chk("R5 second transfer", {hi, lo}, 4);

    // R8: error in the transfer cycle goes to the new interval
    step("R8", 0, 0, 0, 0, 2'b10, 0, 0);
    step("R8", 0, 0, 1, 0, 2'b10, 0, 1);
    chk("R8 old interval", {hi, lo}, 0);
    step("R8", 0, 0, 0, 0, 2'b10, 0, 0);
    readout("R8", 1'b0);
    chk("R8 new interval", {hi, lo}, 1);

    // R6: manual tick ignored, auto mode ignores bit
    step("R6", 0, 0, 1, 1, 2'b10, 0, 0);
    chk("R6 manual tick no transfer", {hi, lo}, 1);
    step("R6", 0, 0, 1, 0, 2'b10, 1, 1);
    step("R6", 0, 0, 0, 0, 2'b10, 1, 0);
    step("R6", 0, 0, 0, 0, 2'b10, 1, 1);
    chk("R6 auto bit ignored", {hi, lo}, 1);
    readout("R6", 1'b1);
    chk("R6 auto tick transfer", {hi, lo}, 2);

    // random mix
    for (int i = 0; i < 3000; i++) begin
      logic a;
      a = logic'($urandom_range(0, 1));
      step("RND", logic'($urandom_range(0, 1)), logic'($urandom_range(0, 2) == 0),
           logic'($urandom_range(0, 1)), logic'($urandom_range(0, 40) == 0),
           2'($urandom_range(0, 3)), (i / 500) % 2 == 1,
           logic'($urandom_range(0, 3) == 0));
      if (a) ;
    end

    // R7: saturation with paired errors
    readout("R7", 1'b0);
    for (int i = 0; i < 32770; i++) step("R7", 0, 1, 1, 0, 2'b11, 0, 0);
    step("R7", 0, 0, 0, 0, 2'b11, 0, 1);
    chk("R7 saturated value", {hi, lo}, 16'hFFFF);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule